// File: doc/BRIEF.md
# Dual-Channel DAC Serial Frame Writer

This block is a transmit-only serial master that loads 16-bit codes into a two-channel serial DAC over three wires: a serial clock, a data line and an active-low frame sync. A host offers one request at a time through a valid/ready handshake. Each request carries a channel select, a 16-bit code and, when needed, a raw control byte. The block builds a 24-bit frame and holds sync low across all of it. It lets sync rise only once the shifter has emptied. It then keeps sync high for a minimum gap before the next frame can start.

Each channel has a shadow copy of the last code sent to it. A normal write whose code equals that copy finishes at once with a done pulse and no bus activity. Raw writes are always sent. The bit rate comes from the system clock through a run-time half-period setting.

Top module: `dac_frame_writer`

## Requirements
- R1: A frame is 24 bits sent most significant bit first: the control byte, then the upper data byte, then the lower data byte. The DAC reads the frame as {ctrl[7:0], data[15:0]}.
- R2: With `req_raw`=0, `req_chan`=0 selects control byte 0x10 and `req_chan`=1 selects control byte 0x24.
- R3: With `req_raw`=1, the frame's control byte is `req_ctrl` unchanged. Such a request is always sent and leaves both shadow copies as they were.
- R4: `sclk` is low whenever `sync_n` is high, and every frame has exactly 24 rising `sclk` edges.
- R5: `sdo` changes only together with a rising `sclk` edge and is stable when `sclk` falls.
- R6: `sync_n` falls at least H system clocks before the first rising `sclk` edge. It rises only after the 24th falling edge, with the shifter empty, and H system clocks after that edge.
- R7: Between two frames `sync_n` stays high for at least `gap_min` system clocks.
- R8: `req_ready` is low from the acceptance of a sent frame until its gap has elapsed. `done` is a one-cycle pulse, given once for every accepted request.
- R9: A normal request whose code equals the shadow copy of its own channel causes no `sync_n` or `sclk` activity. It raises `done` in the cycle after acceptance. The two channels are compared separately.
- R10: After reset `sync_n` is high, `sclk` low, `sdo` low and `req_ready` high. Both shadow copies are invalid, so the first normal write to each channel is sent even when its code is 0x0000.
- R11: Each `sclk` high and low phase lasts H = `half_div` system clocks, where a value of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | System clocks per half bit period |
| gap_min | input | GAP_W | Minimum sync-high clocks between frames |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_chan | input | 1 | Channel select (0 or 1) |
| req_raw | input | 1 | Send req_ctrl as the control byte, bypassing the shadow check |
| req_ctrl | input | 8 | Raw control byte |
| req_data | input | 16 | Code to load |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sync_n | output | 1 | Active-low frame sync |

## Verification
The bench builds the block with DIV_W and GAP_W set to 8, so that the half-period and gap settings can be driven to their small corner values. It runs frames with H of 1, 2 and 3, including the zero setting that counts as 1, so every lead, high, low and tail phase can be measured in exact cycles. A gap of 6 with back-to-back requests shows that the sync-high window is enforced rather than coming from bench pacing.

// File: rtl/dfw_pkg.sv
package dfw_pkg;
  localparam int DFW_CTRL_W  = 8;
  localparam int DFW_DATA_W  = 16;
  localparam int DFW_FRAME_W = DFW_CTRL_W + DFW_DATA_W;

  localparam logic [DFW_CTRL_W-1:0] CTRL_CH0 = 8'h10;
  localparam logic [DFW_CTRL_W-1:0] CTRL_CH1 = 8'h24;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } dfw_state_e;

  function automatic logic [DFW_CTRL_W-1:0] ctrl_for(input logic sel);
    return sel ? CTRL_CH1 : CTRL_CH0;
  endfunction

  function automatic logic [DFW_FRAME_W-1:0] build_frame(
    input logic [DFW_CTRL_W-1:0] ctrl,
    input logic [DFW_DATA_W-1:0] code
  );
    return {ctrl, code[DFW_DATA_W-1 -: 8], code[7:0]};
  endfunction
endpackage

// File: rtl/dfw_halfbit_timer.sv
module dfw_halfbit_timer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = (half_div == '0) ? '0 : half_div - DIV_W'(1);
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end
endmodule

// File: rtl/dfw_shifter.sv
module dfw_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rise,
  input  logic               fall,
  input  logic               release_line,
  output logic               sclk,
  output logic               sdo,
  output logic               empty
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   left;

  assign empty = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
      sclk <= 1'b0;
      sdo  <= 1'b0;
    end else if (load) begin
      sr   <= frame_in;
      left <= CNT_W'(FRAME_W);
      sclk <= 1'b0;
      sdo  <= 1'b0;
    end else if (rise && !empty) begin
      sdo  <= sr[FRAME_W-1];
      sr   <= {sr[FRAME_W-2:0], 1'b0};
      left <= left - CNT_W'(1);
      sclk <= 1'b1;
    end else if (fall) begin
      sclk <= 1'b0;
    end else if (release_line) begin
      sdo  <= 1'b0;
    end
  end
endmodule

// File: rtl/dfw_shadow.sv
module dfw_shadow #(
  parameter int CHANNELS = 2,
  parameter int DATA_W   = 16,
  localparam int SEL_W   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] value,
  input  logic              wr,
  output logic              hit
);
  logic [CHANNELS-1:0] hit_vec;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    logic              held_ok;
    logic [DATA_W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_ok <= 1'b0;
        held    <= '0;
      end else if (wr && sel == SEL_W'(ch)) begin
        held_ok <= 1'b1;
        held    <= value;
      end
    end

    assign hit_vec[ch] = held_ok && (held == value);
  end

  assign hit = hit_vec[sel];
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer #(
  parameter int DIV_W = 12,
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic [GAP_W-1:0] gap_min,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_chan,
  input  logic             req_raw,
  input  logic [7:0]       req_ctrl,
  input  logic [15:0]      req_data,
  output logic             done,
  output logic             sclk,
  output logic             sdo,
  output logic             sync_n
);
  import dfw_pkg::*;

  localparam int FRAME_W = DFW_FRAME_W;
  localparam int EDGE_W  = $clog2(2 * FRAME_W + 2);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * FRAME_W);

  dfw_state_e        state;
  logic [EDGE_W-1:0] edge_cnt;
  logic [GAP_W-1:0]  gcnt;

  logic               tick;
  logic               in_frame;
  logic               accept;
  logic               skip_hit;
  logic               send_evt;
  logic               shadow_match;
  logic               rise_evt;
  logic               fall_evt;
  logic               release_evt;
  logic               sh_empty;
  logic               gap_over;
  logic [FRAME_W-1:0] frame_word;

  assign req_ready   = (state == ST_IDLE);
  assign in_frame    = (state == ST_FRAME);
  assign accept      = req_valid && req_ready;
  assign skip_hit    = accept && !req_raw && shadow_match;
  assign send_evt    = accept && !skip_hit;
  assign rise_evt    = in_frame && tick && (edge_cnt < LAST_EDGE) && !edge_cnt[0];
  assign fall_evt    = in_frame && tick && (edge_cnt < LAST_EDGE) && edge_cnt[0];
  assign release_evt = in_frame && tick && (edge_cnt == LAST_EDGE) && sh_empty && !sclk;
  assign gap_over    = ({1'b0, gcnt} + (GAP_W + 1)'(1)) >= {1'b0, gap_min};
  assign frame_word  = build_frame(req_raw ? req_ctrl : ctrl_for(req_chan), req_data);

  dfw_halfbit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_frame),
    .half_div (half_div),
    .tick     (tick)
  );

  dfw_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (send_evt),
    .frame_in     (frame_word),
    .rise         (rise_evt),
    .fall         (fall_evt),
    .release_line (release_evt),
    .sclk         (sclk),
    .sdo          (sdo),
    .empty        (sh_empty)
  );

  dfw_shadow #(.CHANNELS(2), .DATA_W(DFW_DATA_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (req_chan),
    .value (req_data),
    .wr    (send_evt && !req_raw),
    .hit   (shadow_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sync_n   <= 1'b1;
      done     <= 1'b0;
      edge_cnt <= '0;
      gcnt     <= '0;
    end else begin
      done <= skip_hit || release_evt;
      unique case (state)
        ST_IDLE: begin
          if (send_evt) begin
            state    <= ST_FRAME;
            sync_n   <= 1'b0;
            edge_cnt <= '0;
          end
        end
        ST_FRAME: begin
          if (release_evt) begin
            sync_n <= 1'b1;
            gcnt   <= '0;
            state  <= ST_GAP;
          end else if (rise_evt || fall_evt) begin
            edge_cnt <= edge_cnt + EDGE_W'(1);
          end
        end
        ST_GAP: begin
          if (gap_over) state <= ST_IDLE;
          else          gcnt  <= gcnt + GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dfw_checks.sv
module dfw_checks (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdo,
  input logic sync_n,
  input logic req_ready,
  input logic done,
  input logic sh_empty
);
  AST_SCLK_LOW_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk); // R4

  AST_SDO_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdo)); // R5

  AST_SYNC_RISE_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> $past(sh_empty)); // R6

  AST_READY_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> !req_ready); // R8

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> done); // R8

  AST_SDO_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sdo); // R10
endmodule

bind dac_frame_writer dfw_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .sdo       (sdo),
  .sync_n    (sync_n),
  .req_ready (req_ready),
  .done      (done),
  .sh_empty  (sh_empty)
);

// File: tb/dac_frame_writer_test.sv
`timescale 1ns/1ps
module dac_frame_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic [7:0]  gap_min = 8'd2;
  logic        req_valid = 1'b0;
  logic        req_chan = 1'b0;
  logic        req_raw = 1'b0;
  logic [7:0]  req_ctrl = 8'h00;
  logic [15:0] req_data = 16'h0000;
  logic        req_ready, done, sclk, sdo, sync_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dac_frame_writer #(.DIV_W(8), .GAP_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .gap_min(gap_min),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_raw(req_raw), .req_ctrl(req_ctrl), .req_data(req_data),
    .done(done), .sclk(sclk), .sdo(sdo), .sync_n(sync_n)
  );

  // bus monitor, sampled on the falling system clock edge
  logic        p_sclk = 1'b0, p_sync = 1'b1;
  logic [23:0] cap = '0, last_frame = '0;
  int frames = 0, falls = 0, dones = 0, bad_clk = 0;
  int bits = 0, rises = 0, last_bits = 0, last_rises = 0;
  int lead = 0, last_lead = 0, hi = 0, hi_min = 0, hi_max = 0;
  int tail = 0, last_tail = 0, high_run = 0, last_gap = 0;
  bit seen_rise = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) dones++;
      if (p_sync && !sync_n) begin
        falls++; last_gap = high_run; high_run = 0;
        lead = 0; seen_rise = 0; cap = '0; bits = 0; rises = 0;
        hi_min = 1000; hi_max = 0;
      end
      if (sync_n) high_run++;
      if (!p_sclk && sclk) begin
        rises++; seen_rise = 1; hi = 0;
        if (sync_n) bad_clk++;
      end
      if (sclk) hi++;
      if (!sync_n && !seen_rise && !sclk) lead++;
      if (p_sclk && !sclk) begin
        cap = {cap[22:0], sdo}; bits++; tail = 0;
        if (hi < hi_min) hi_min = hi;
        if (hi > hi_max) hi_max = hi;
      end
      if (!sync_n && seen_rise && !sclk) tail++;
      if (!p_sync && sync_n) begin
        frames++; last_frame = cap; last_bits = bits; last_rises = rises;
        last_lead = lead; last_tail = tail;
      end
    end
    p_sclk = sclk; p_sync = sync_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic ch, input logic raw, input logic [7:0] c,
                       input logic [15:0] d, output bit ready_dropped);
    int d0;
    d0 = dones;
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_raw = raw; req_ctrl = c; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ready_dropped = !req_ready;
    while (dones == d0) @(negedge clk);
    @(negedge clk);
    chk(dones == d0 + 1, "R8", "done pulses per request", dones - d0, 1);
  endtask

  task automatic sent_frame(input logic ch, input logic raw, input logic [7:0] c,
                            input logic [15:0] d, input logic [23:0] exp, input string req);
    int f0; bit rd;
    f0 = frames;
    issue(ch, raw, c, d, rd);
    chk(frames == f0 + 1, req, "frame count", frames - f0, 1);
    chk(last_frame == exp, req, "frame content", last_frame, exp);
    chk(last_bits == 24 && last_rises == 24, "R4", "sclk edges", last_rises, 24);
    chk(rd, "R8", "ready low after acceptance", rd, 1);
  endtask

  task automatic skipped(input logic ch, input logic [15:0] d, input string req);
    int f0; int s0; bit rd;
    f0 = falls; s0 = frames;
    issue(ch, 1'b0, 8'h00, d, rd);
    repeat (8) @(negedge clk);
    chk(falls == f0 && frames == s0, req, "no sync activity on skip", falls - f0, 0);
  endtask

  task automatic t_reset;
    chk(sync_n && !sclk && !sdo && req_ready && !done, "R10", "reset outputs",
        {sync_n, sclk, sdo, req_ready, done}, 5'b10010);
    sent_frame(1'b0, 1'b0, 8'h00, 16'h0000, 24'h100000, "R10");
    sent_frame(1'b1, 1'b0, 8'h00, 16'h0000, 24'h240000, "R10");
  endtask

  task automatic t_channels;
    sent_frame(1'b0, 1'b0, 8'h00, 16'h1234, 24'h101234, "R1");
    sent_frame(1'b1, 1'b0, 8'h00, 16'hABCD, 24'h24ABCD, "R2");
  endtask

  task automatic t_skip;
    skipped(1'b0, 16'h1234, "R9");
    sent_frame(1'b1, 1'b0, 8'h00, 16'h1234, 24'h241234, "R9");
    skipped(1'b1, 16'h1234, "R9");
  endtask

  task automatic t_raw;
    sent_frame(1'b0, 1'b1, 8'h30, 16'hFFFF, 24'h30FFFF, "R3");
    sent_frame(1'b0, 1'b1, 8'h30, 16'hFFFF, 24'h30FFFF, "R3");
    skipped(1'b0, 16'h1234, "R3");
  endtask

  task automatic t_timing(input logic [7:0] hd, input int h);
    half_div = hd;
    sent_frame(1'b1, 1'b0, 8'h00, 16'h0F00 + 16'(h), 24'h240F00 + 24'(h), "R11");
    chk(hi_min == h && hi_max == h, "R11", "sclk high phase", hi_max, h);
    chk(last_lead >= h, "R6", "lead before first rise", last_lead, h);
    chk(last_tail == h, "R6", "tail after last fall", last_tail, h);
  endtask

  task automatic t_gap;
    bit rd;
    half_div = 8'd1; gap_min = 8'd6;
    issue(1'b0, 1'b0, 8'h00, 16'h5555, rd);
    issue(1'b0, 1'b0, 8'h00, 16'hAAAA, rd);
    chk(last_frame == 24'h10AAAA, "R7", "second frame content", last_frame, 24'h10AAAA);
    chk(last_gap >= 6, "R7", "sync high gap", last_gap, 6);
    chk(bad_clk == 0, "R4", "sclk edges outside frames", bad_clk, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_channels;
    t_skip;
    t_raw;
    t_timing(8'd3, 3);
    t_timing(8'd0, 1);
    t_timing(8'd2, 2);
    t_gap;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule